// File: doc/BRIEF.md
# Hybrid BIST Pattern Sequencer

This block is a self-test controller for a combinational circuit under test. After a start pulse it drives the circuit's input bus in two phases. The first phase applies a programmable number of pseudo-random patterns from a run-time loadable LFSR. The second phase, which begins at that programmable breakpoint, replays a programmable number of stored deterministic patterns. These are read in address order from a small external pattern table and target faults that random patterns seldom reach.

The circuit's response to each applied pattern returns on the response bus in the same cycle. A multiple-input signature register compacts the responses of both phases into a single signature. The signature is held once the run ends. A one-cycle done pulse marks the end of the run.

The LFSR form is chosen at build time. One form uses external feedback, with the XOR of all tapped bits shifted in. The other uses internal feedback, with the polynomial XORed into the shifted state when the outgoing bit is set. A phase length of zero removes that phase, so the same block can run a purely random test or a purely stored test.

Top module: `hybrid_pattern_seq`

## Requirements
- R1: After reset, patValid, phaseDet and done are low and signature is zero.
- R2: A start pulse latches seedIn and polyIn. In the next cycle the first random pattern on patOut equals the latched seed. Changes on seedIn or polyIn after the start cycle have no effect on the run.
- R3: A seedIn of zero is replaced by the nonzero default seed 16'h0001, so the LFSR never holds the all-zero state.
- R4: One pattern is presented per clock while patValid is high. With LFSR_TYPE=0 (external feedback) the next state of S under polynomial P is {S[W-2:0], ^(S & P)}. With LFSR_TYPE=1 (internal feedback) it is {S[W-2:0], 1'b0} ^ (S[W-1] ? P : 0).
- R5: After randLen random cycles with phaseDet low, the block presents M table patterns with phaseDet high. tblAddr runs 0, 1, ..., M-1, and patOut equals tblData in the same cycle. The block never returns to the random phase within a run.
- R6: patValid is high for exactly randLen + M consecutive cycles after the start cycle. done is high for exactly one cycle, the one after the last pattern, and is never high together with patValid.
- R7: The start pulse clears the signature to zero. In each cycle with patValid high the signature G becomes {G[W-2:0], 1'b0} ^ (G[W-1] ? MISR_POLY : 0) ^ rspIn, with MISR_POLY = 16'h1021. When patValid is low and no start occurs, the signature does not change.
- R8: M = 0 gives a purely random run. randLen = 0 gives a purely stored run with phaseDet high from its first cycle. Both zero gives no patterns and done in the cycle after start.
- R9: A detCount above the table depth (16) is clamped to the depth, and tblAddr stays below the depth.
- R10: A start pulse during a run abandons it. The next cycle shows the new seed and a zero signature, and the new run proceeds as in R2 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request to begin (or restart) a run |
| seedIn | input | PAT_W | LFSR seed, latched at start |
| polyIn | input | PAT_W | LFSR feedback polynomial, latched at start |
| randLen | input | CNT_W | Number of pseudo-random patterns (breakpoint) |
| detCount | input | MCNT_W | Number of stored patterns M |
| tblAddr | output | TBL_AW | Pattern table read address |
| tblData | input | PAT_W | Pattern table read data, same cycle |
| rspIn | input | RSP_W | Response of the circuit under test to patOut |
| patOut | output | PAT_W | Pattern applied to the circuit under test |
| patValid | output | 1 | patOut carries a pattern this cycle |
| phaseDet | output | 1 | High during the stored-pattern phase |
| done | output | 1 | One-cycle pulse after the last pattern |
| signature | output | RSP_W | Compacted response signature |

## Verification
The hardest situation to reach from the ports is a restart that arrives in the middle of a random phase. At that moment the LFSR, the signature and both counters are all partly advanced, and each must be discarded in the same edge. The stimulus abandons a run after a few patterns and issues a new start with a different seed and breakpoint. It then follows the new run cycle by cycle. Two instances, one per LFSR form, share every input. The bench also scrambles seedIn and polyIn right after each start, so a design that failed to latch them would show at once in the pattern stream.

// File: rtl/hbist_pkg.sv
package hbist_pkg;

  // Strobes from the sequencing control to the datapath, valid for one cycle.
  typedef struct packed {
    logic loadSeed;   // latch seed and polynomial
    logic stepLfsr;   // advance the generator
    logic clearMisr;  // zero the signature
    logic compact;    // fold rspIn into the signature
  } hbistStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAND = 2'd1,
    ST_DET  = 2'd2
  } hbistState_t;

endpackage

// File: rtl/hbist_ctrl.sv
module hbist_ctrl
  import hbist_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int TBL_DEPTH = 16,
  parameter int TBL_AW    = 4,
  parameter int MCNT_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [CNT_W-1:0]    randLen,
  input  logic [MCNT_W-1:0]   detCount,
  output hbistStrobe_t        strobes,
  output logic                patValid,
  output logic                phaseDet,
  output logic                done,
  output logic [TBL_AW-1:0]   tblAddr
);

  hbistState_t         state;
  logic [CNT_W-1:0]    remCnt;
  logic [MCNT_W-1:0]   detLeft;
  logic [TBL_AW-1:0]   idx;
  logic [MCNT_W-1:0]   mEff;

  // Clamp the stored-pattern count to the table depth (R9).
  always_comb begin
    if (detCount > MCNT_W'(TBL_DEPTH)) mEff = MCNT_W'(TBL_DEPTH);
    else                               mEff = detCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      remCnt  <= '0;
      detLeft <= '0;
      idx     <= '0;
    end else begin
      done <= 1'b0;
      if (startPulse) begin
        idx     <= '0;
        detLeft <= mEff;
        remCnt  <= randLen;
        if (randLen != '0)   state <= ST_RAND;
        else if (mEff != '0) state <= ST_DET;
        else begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end else begin
        case (state)
          ST_RAND: begin
            remCnt <= remCnt - 1'b1;
            if (remCnt == CNT_W'(1)) begin
              if (detLeft != '0) state <= ST_DET;
              else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end
          end
          ST_DET: begin
            idx     <= idx + 1'b1;
            detLeft <= detLeft - 1'b1;
            if (detLeft == MCNT_W'(1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign patValid = (state != ST_IDLE);
  assign phaseDet = (state == ST_DET);
  assign tblAddr  = idx;

  always_comb begin
    strobes.loadSeed  = startPulse;
    strobes.clearMisr = startPulse;
    strobes.stepLfsr  = !startPulse && (state == ST_RAND);
    strobes.compact   = !startPulse && (state != ST_IDLE);
  end

endmodule

// File: rtl/hbist_dp.sv
module hbist_dp
  import hbist_pkg::*;
#(
  parameter int              PAT_W     = 16,
  parameter int              RSP_W     = 16,
  parameter int              LFSR_TYPE = 0,
  parameter logic [PAT_W-1:0] DEF_SEED  = PAT_W'(1),
  parameter logic [RSP_W-1:0] MISR_POLY = RSP_W'(16'h1021)
) (
  input  logic               clk,
  input  logic               rstN,
  input  hbistStrobe_t       strobes,
  input  logic [PAT_W-1:0]   seedIn,
  input  logic [PAT_W-1:0]   polyIn,
  input  logic [RSP_W-1:0]   rspIn,
  input  logic               phaseDet,
  input  logic [PAT_W-1:0]   tblData,
  output logic [PAT_W-1:0]   patOut,
  output logic [RSP_W-1:0]   signature
);

  logic [PAT_W-1:0] lfsrQ, polyQ, lfsrNext, seedSafe;
  logic [RSP_W-1:0] misrQ, misrNext;

  generate
    if (LFSR_TYPE == 0) begin : g_extFeedback
      always_comb lfsrNext = {lfsrQ[PAT_W-2:0], ^(lfsrQ & polyQ)};
    end else begin : g_intFeedback
      always_comb lfsrNext = {lfsrQ[PAT_W-2:0], 1'b0} ^ (lfsrQ[PAT_W-1] ? polyQ : '0);
    end
  endgenerate

  assign seedSafe = (seedIn == '0) ? DEF_SEED : seedIn;
  assign misrNext = {misrQ[RSP_W-2:0], 1'b0} ^ (misrQ[RSP_W-1] ? MISR_POLY : '0) ^ rspIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= DEF_SEED;
      polyQ <= '0;
      misrQ <= '0;
    end else begin
      if (strobes.loadSeed) begin
        lfsrQ <= seedSafe;
        polyQ <= polyIn;
      end else if (strobes.stepLfsr) begin
        lfsrQ <= lfsrNext;
      end
      if (strobes.clearMisr)    misrQ <= '0;
      else if (strobes.compact) misrQ <= misrNext;
    end
  end

  assign patOut    = phaseDet ? tblData : lfsrQ;
  assign signature = misrQ;

endmodule

// File: rtl/hybrid_pattern_seq.sv
module hybrid_pattern_seq
  import hbist_pkg::*;
#(
  parameter int               PAT_W     = 16,
  parameter int               RSP_W     = 16,
  parameter int               CNT_W     = 16,
  parameter int               TBL_DEPTH = 16,
  parameter int               LFSR_TYPE = 0,
  parameter logic [PAT_W-1:0] DEF_SEED  = PAT_W'(1),
  parameter logic [RSP_W-1:0] MISR_POLY = RSP_W'(16'h1021),
  localparam int              TBL_AW    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  localparam int              MCNT_W    = $clog2(TBL_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [PAT_W-1:0]   seedIn,
  input  logic [PAT_W-1:0]   polyIn,
  input  logic [CNT_W-1:0]   randLen,
  input  logic [MCNT_W-1:0]  detCount,
  output logic [TBL_AW-1:0]  tblAddr,
  input  logic [PAT_W-1:0]   tblData,
  input  logic [RSP_W-1:0]   rspIn,
  output logic [PAT_W-1:0]   patOut,
  output logic               patValid,
  output logic               phaseDet,
  output logic               done,
  output logic [RSP_W-1:0]   signature
);

  hbistStrobe_t strobes;

  hbist_ctrl #(
    .CNT_W(CNT_W), .TBL_DEPTH(TBL_DEPTH), .TBL_AW(TBL_AW), .MCNT_W(MCNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .randLen(randLen),
    .detCount(detCount), .strobes(strobes), .patValid(patValid),
    .phaseDet(phaseDet), .done(done), .tblAddr(tblAddr)
  );

  hbist_dp #(
    .PAT_W(PAT_W), .RSP_W(RSP_W), .LFSR_TYPE(LFSR_TYPE),
    .DEF_SEED(DEF_SEED), .MISR_POLY(MISR_POLY)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .seedIn(seedIn), .polyIn(polyIn),
    .rspIn(rspIn), .phaseDet(phaseDet), .tblData(tblData),
    .patOut(patOut), .signature(signature)
  );

endmodule

// File: rtl/hbist_chk.sv
module hbist_chk #(
  parameter int               PAT_W     = 16,
  parameter int               RSP_W     = 16,
  parameter int               CNT_W     = 16,
  parameter int               TBL_DEPTH = 16,
  parameter int               TBL_AW    = 4,
  parameter int               MCNT_W    = 5,
  parameter logic [PAT_W-1:0] DEF_SEED  = PAT_W'(1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic [PAT_W-1:0]  seedIn,
  input logic [CNT_W-1:0]  randLen,
  input logic [TBL_AW-1:0] tblAddr,
  input logic [PAT_W-1:0]  patOut,
  input logic              patValid,
  input logic              phaseDet,
  input logic              done,
  input logic [RSP_W-1:0]  signature
);

  // R2: first random pattern is the seed given with the start pulse
  assert_seed_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && seedIn != '0 && randLen != '0 |=> patOut == $past(seedIn));

  // R3: zero seed replaced by the default
  assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && seedIn == '0 && randLen != '0 |=> patOut == DEF_SEED);

  // R5: no return to the random phase once stored patterns started
  assert_no_phase_back_R5: assert property (@(posedge clk) disable iff (!rstN)
    patValid && phaseDet && !startPulse |=> !patValid || phaseDet);

  // R6: done never overlaps a pattern and lasts one cycle
  assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(patValid && done));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && !startPulse |=> !done);

  // R7: start clears the signature, idle keeps it
  assert_sig_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> signature == '0);
  assert_sig_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !patValid && !startPulse |=> $stable(signature));

  // R9: table address stays inside the table
  assert_addr_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    patValid && phaseDet |-> int'(tblAddr) < TBL_DEPTH);

endmodule

bind hybrid_pattern_seq hbist_chk #(
  .PAT_W(PAT_W), .RSP_W(RSP_W), .CNT_W(CNT_W), .TBL_DEPTH(TBL_DEPTH),
  .TBL_AW(TBL_AW), .MCNT_W(MCNT_W), .DEF_SEED(DEF_SEED)
) chk_i (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .seedIn(seedIn),
  .randLen(randLen), .tblAddr(tblAddr), .patOut(patOut), .patValid(patValid),
  .phaseDet(phaseDet), .done(done), .signature(signature)
);

// File: tb/hybrid_pattern_seq_tb_top.sv
`timescale 1ns/1ps
module hybrid_pattern_seq_tb_top;
  localparam int W = 16, CW = 16, D = 16, AW = 4, MW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0, startPulse = 1'b0;
  logic [W-1:0]  seedIn = '0, polyIn = '0;
  logic [CW-1:0] randLen = '0;
  logic [MW-1:0] detCount = '0;

  logic [AW-1:0] tblAddrA, tblAddrB;
  logic [W-1:0]  tblDataA, tblDataB, rspA, rspB, patA, patB, sigA, sigB;
  logic          validA, validB, phA, phB, doneA, doneB;
  logic [W-1:0]  tbl [D];

  function automatic logic [W-1:0] rspFn(input logic [W-1:0] p);
    return p ^ {p[10:0], p[15:11]} ^ 16'h5A5A;
  endfunction
  function automatic logic [W-1:0] extNext(input logic [W-1:0] s, input logic [W-1:0] p);
    return {s[14:0], ^(s & p)};
  endfunction
  function automatic logic [W-1:0] intNext(input logic [W-1:0] s, input logic [W-1:0] p);
    return {s[14:0], 1'b0} ^ (s[15] ? p : 16'h0);
  endfunction
  function automatic logic [W-1:0] misrStep(input logic [W-1:0] g, input logic [W-1:0] r);
    return {g[14:0], 1'b0} ^ (g[15] ? 16'h1021 : 16'h0) ^ r;
  endfunction

  assign tblDataA = tbl[tblAddrA];
  assign tblDataB = tbl[tblAddrB];
  assign rspA = rspFn(patA);
  assign rspB = rspFn(patB);

  hybrid_pattern_seq #(.LFSR_TYPE(0)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .seedIn(seedIn), .polyIn(polyIn),
    .randLen(randLen), .detCount(detCount), .tblAddr(tblAddrA), .tblData(tblDataA),
    .rspIn(rspA), .patOut(patA), .patValid(validA), .phaseDet(phA), .done(doneA),
    .signature(sigA));

  hybrid_pattern_seq #(.LFSR_TYPE(1)) dut2_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .seedIn(seedIn), .polyIn(polyIn),
    .randLen(randLen), .detCount(detCount), .tblAddr(tblAddrB), .tblData(tblDataB),
    .rspIn(rspB), .patOut(patB), .patValid(validB), .phaseDet(phB), .done(doneB),
    .signature(sigB));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One run compared cycle by cycle against a behavioural model.
  task automatic runTest(input logic [W-1:0] seed, input logic [W-1:0] poly,
                         input int rl, input int m, input int stopAt,
                         input string firstTag, input string endTag);
    int mEff;
    logic [W-1:0] sA, sB, gA, gB, eA, eB;
    mEff = (m > D) ? D : m;
    sA = (seed == 16'h0) ? 16'h0001 : seed;
    sB = sA;
    gA = '0; gB = '0;
    @(negedge clk);
    startPulse = 1'b1; seedIn = seed; polyIn = poly;
    randLen = CW'(rl); detCount = MW'(m);
    @(negedge clk);
    startPulse = 1'b0; seedIn = ~seed; polyIn = poly ^ 16'h0F0F; // R2: must be ignored
    for (int k = 0; k < rl + mEff; k++) begin
      string tag;
      if (stopAt >= 0 && k == stopAt) return;
      tag = (k == 0) ? firstTag : ((k < rl) ? "R4" : "R5");
      if (k < rl) begin eA = sA; eB = sB; end
      else begin eA = tbl[k-rl]; eB = tbl[k-rl]; end
      chk(validA === 1'b1 && validB === 1'b1, "R6", "valid", {validA, validB}, 2'b11);
      chk(phA === (k >= rl) && phB === (k >= rl), tag, "phase", {phA, phB}, {2{k >= rl}});
      chk(patA === eA, tag, "pattern ext-feedback", patA, eA);
      chk(patB === eB, tag, "pattern int-feedback", patB, eB);
      if (k >= rl) chk(tblAddrA === AW'(k-rl), "R5", "tblAddr", tblAddrA, k-rl);
      chk(sigA === gA && sigB === gB, (k == 0) ? firstTag : "R7", "running signature",
          {sigA, sigB}, {gA, gB});
      chk(doneA === 1'b0, "R6", "done early", doneA, 0);
      gA = misrStep(gA, rspFn(eA));
      gB = misrStep(gB, rspFn(eB));
      if (k < rl) begin sA = extNext(sA, poly); sB = intNext(sB, poly); end
      @(negedge clk);
    end
    chk(doneA === 1'b1 && doneB === 1'b1 && validA === 1'b0, endTag, "done at end",
        {doneA, doneB, validA}, 3'b110);
    chk(sigA === gA, "R7", "final signature ext", sigA, gA);
    chk(sigB === gB, "R7", "final signature int", sigB, gB);
    @(negedge clk);
    chk(doneA === 1'b0 && validA === 1'b0, "R6", "done one cycle", {doneA, validA}, 0);
    chk(sigA === gA && sigB === gB, "R7", "signature held", {sigA, sigB}, {gA, gB});
  endtask

  initial begin
    for (int i = 0; i < D; i++) tbl[i] = W'(16'h1357 * (i + 1)) ^ W'(i << 8);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(validA === 1'b0 && phA === 1'b0 && doneA === 1'b0, "R1", "outputs in reset",
        {validA, phA, doneA}, 0);
    chk(sigA === '0 && sigB === '0, "R1", "signature in reset", {sigA, sigB}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(validA === 1'b0 && doneA === 1'b0, "R1", "idle after reset", {validA, doneA}, 0);

    runTest(16'hACE1, 16'hB400, 20, 5, -1, "R2", "R6");   // hybrid run
    runTest(16'h0000, 16'hD008, 8, 3, -1, "R3", "R6");    // zero seed
    runTest(16'h1234, 16'h8016, 10, 0, -1, "R2", "R8");   // random only
    runTest(16'h4321, 16'hB400, 0, 4, -1, "R8", "R8");    // stored only
    runTest(16'h7777, 16'hB400, 0, 0, -1, "R8", "R8");    // empty run
    runTest(16'h0F0F, 16'hA001, 6, 20, -1, "R2", "R9");   // clamp to depth
    runTest(16'hBEEF, 16'hB400, 30, 4, 7, "R2", "R10");   // abandoned mid-run
    runTest(16'h5A01, 16'h9C00, 12, 6, -1, "R10", "R10"); // restart
    runTest(16'hFFFF, 16'hFFFF, 40, 16, -1, "R4", "R6");  // dense polynomial, full table
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule